// File: doc/BRIEF.md
# Six-State Table-Driven Sequence Controller

This block is a synchronous Mealy controller that steps through a fixed six-state transition table. It takes a 3-bit input symbol and drives a 3-bit action word. The table is the deterministic form of a smaller machine in which several control points can be live together. In that smaller machine a control point with no matching arc disappears, several matching arcs each start a new control point, and an action bit is set if any live point sets it. Each table state stands for one set of live points. This means the controller can stand in where that multi-point behaviour is needed while holding only one state register.

The action word is a combinational function of the registered state and the present input symbol. On each rising clock edge the controller loads the next state. A synchronous, active-high reset loads state S2. A parameter chooses how the state register is encoded, either packed binary or one-hot. Both choices must give the same behaviour at the ports.

Top module: `seqctl_top`

## Requirements
- R1: A clock edge with `rst` high makes the state S2 on the next cycle, whatever the input. While `rst` is high, the action word still follows the table for the current state and input.
- R2: An input symbol with `sym_in[2]`=0 moves every state to S2. The action word is 3'b100 from S0 and S1, and 3'b000 from the other states.
- R3: From S0 with `sym_in[2]`=1: 100→S0/000, 101→S1/000, 110→S0/001, 111→S1/001 (input and action written as bits [2:0]).
- R4: From S1 with `sym_in[2]`=1: 100→S0/000, 101→S1/010, 110→S0/001, 111→S1/011.
- R5: From S2: 111→S3/001, 110→S4/001, 101→S5/000. Every other symbol stays in S2 with action 000.
- R6: From S3 with `sym_in[2]`=1: 100→S0/000, 101→S1/010, 110→S0/001, 111→S1/011.
- R7: From S4 with `sym_in[2]`=1: 100→S0/000, 101→S1/000, 110→S0/001, 111→S1/001.
- R8: From S5 with `sym_in[2]`=1: 100→S2/000, 101→S3/010, 110→S4/001, 111→S3/011.
- R9: `act_out` changes in the same cycle as `sym_in`, with no clock edge in between. The state advances only on a rising edge of `clk`.
- R10: An input symbol with any unknown bit gives action 000 and next state S2. The state register never holds a code outside the six legal codes.
- R11: The binary and one-hot encodings (`ONE_HOT`=0 and 1) produce the same action sequence for the same input and reset sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to S2 |
| sym_in | input | 3 | Input symbol, sampled at each rising edge |
| act_out | output | 3 | Mealy action word from current state and input |

## Verification
The bench builds two instances side by side, one with `ONE_HOT`=0 (three-bit packed state) and one with `ONE_HOT`=1 (six-bit state). Each instance is compared to a behavioural model on every cycle. With both instances present, any difference between the encodings shows up directly, as well as any table error in either one. A directed sweep reaches every state and applies all eight symbols there. A long pseudo-random walk covers chains of transitions. Symbols with unknown bits are injected in several states to exercise the fallback to S2.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
    localparam int SYM_W = 3;
    localparam int ACT_W = 3;
    localparam int NUM_ST = 6;
    localparam int IDX_W = $clog2(NUM_ST);

    typedef enum logic [IDX_W-1:0] {
        ST_S0 = 3'd0,
        ST_S1 = 3'd1,
        ST_S2 = 3'd2,
        ST_S3 = 3'd3,
        ST_S4 = 3'd4,
        ST_S5 = 3'd5
    } st_idx_e;

    localparam st_idx_e ST_RESET = ST_S2;

    typedef struct packed {
        st_idx_e            nxt;
        logic [ACT_W-1:0]   act;
    } step_t;
endpackage

// File: rtl/seqctl_table.sv
module seqctl_table
    import seqctl_pkg::*;
(
    input  st_idx_e            cur_st,
    input  logic [SYM_W-1:0]   sym,
    output step_t              step
);
    // Symbols not listed for a state, including any with unknown bits,
    // fall to the default branch: back to the reset state, no action.
    always_comb begin
        step.nxt = ST_RESET;
        step.act = '0;
        case (cur_st)
            ST_S0, ST_S1: begin
                case (sym)
                    3'b100: begin step.nxt = ST_S0; step.act = 3'b000; end
                    3'b101: begin step.nxt = ST_S1;
                                  step.act = (cur_st == ST_S1) ? 3'b010 : 3'b000; end
                    3'b110: begin step.nxt = ST_S0; step.act = 3'b001; end
                    3'b111: begin step.nxt = ST_S1;
                                  step.act = (cur_st == ST_S1) ? 3'b011 : 3'b001; end
                    3'b000, 3'b001, 3'b010, 3'b011:
                            begin step.nxt = ST_S2; step.act = 3'b100; end
                    default: begin step.nxt = ST_RESET; step.act = '0; end
                endcase
            end
            ST_S2: begin
                case (sym)
                    3'b111: begin step.nxt = ST_S3; step.act = 3'b001; end
                    3'b110: begin step.nxt = ST_S4; step.act = 3'b001; end
                    3'b101: begin step.nxt = ST_S5; step.act = 3'b000; end
                    default: begin step.nxt = ST_S2; step.act = 3'b000; end
                endcase
            end
            ST_S3, ST_S4: begin
                case (sym)
                    3'b100: begin step.nxt = ST_S0; step.act = 3'b000; end
                    3'b101: begin step.nxt = ST_S1;
                                  step.act = (cur_st == ST_S3) ? 3'b010 : 3'b000; end
                    3'b110: begin step.nxt = ST_S0; step.act = 3'b001; end
                    3'b111: begin step.nxt = ST_S1;
                                  step.act = (cur_st == ST_S3) ? 3'b011 : 3'b001; end
                    default: begin step.nxt = ST_S2; step.act = 3'b000; end
                endcase
            end
            ST_S5: begin
                case (sym)
                    3'b111: begin step.nxt = ST_S3; step.act = 3'b011; end
                    3'b110: begin step.nxt = ST_S4; step.act = 3'b001; end
                    3'b101: begin step.nxt = ST_S3; step.act = 3'b010; end
                    default: begin step.nxt = ST_S2; step.act = 3'b000; end
                endcase
            end
            default: begin step.nxt = ST_RESET; step.act = '0; end
        endcase
    end
endmodule

// File: rtl/seqctl_state_reg.sv
module seqctl_state_reg
    import seqctl_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  st_idx_e nxt_st,
    output st_idx_e cur_st
);
    localparam int ENC_W = ONE_HOT ? NUM_ST : IDX_W;

    logic [ENC_W-1:0] code_d;
    logic [ENC_W-1:0] code_q;

    generate
        if (ONE_HOT) begin : g_onehot
            always_comb begin
                code_d = '0;
                if (rst) code_d[int'(ST_RESET)] = 1'b1;
                else     code_d[int'(nxt_st)]   = 1'b1;
            end

            always_comb begin
                cur_st = ST_RESET;
                for (int i = 0; i < NUM_ST; i++) begin
                    if (code_q[i]) cur_st = st_idx_e'(i[IDX_W-1:0]);
                end
            end

            assert_state_legal_onehot_R10: assert property (
                @(posedge clk) disable iff (rst) $onehot(code_q));
        end else begin : g_binary
            always_comb begin
                code_d = rst ? ENC_W'(ST_RESET) : ENC_W'(nxt_st);
            end

            always_comb begin
                cur_st = st_idx_e'(code_q);
            end

            assert_state_legal_binary_R10: assert property (
                @(posedge clk) disable iff (rst) code_q < ENC_W'(NUM_ST));
        end
    endgenerate

    always_ff @(posedge clk) begin
        code_q <= code_d;
    end
endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
    import seqctl_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SYM_W-1:0]  sym_in,
    output logic [ACT_W-1:0]  act_out
);
    st_idx_e st_q;
    step_t   step_d;

    seqctl_table u_table (
        .cur_st (st_q),
        .sym    (sym_in),
        .step   (step_d)
    );

    seqctl_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
        .clk    (clk),
        .rst    (rst),
        .nxt_st (step_d.nxt),
        .cur_st (st_q)
    );

    assign act_out = step_d.act;

    assert_reset_to_s2_R1: assert property (
        @(posedge clk) rst |=> (st_q == ST_S2));

    assert_lead0_to_s2_R2: assert property (
        @(posedge clk) disable iff (rst)
        (sym_in[2] == 1'b0) |=> (st_q == ST_S2));

    assert_top_bit_lead0_R2: assert property (
        @(posedge clk) disable iff (rst)
        act_out[2] |-> (sym_in[2] == 1'b0));

    // Middle action bit appears only on 1x1 symbols (R4, R6, R8).
    assert_mid_bit_cond_R8: assert property (
        @(posedge clk) disable iff (rst)
        act_out[1] |-> (sym_in[2] && sym_in[0]));

    assert_unknown_no_act_R10: assert property (
        @(posedge clk) disable iff (rst)
        $isunknown(sym_in) |-> (act_out == 3'b000));
endmodule

// File: tb/seqctl_top_tb.sv
module seqctl_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sym_in = 3'b000;
    logic [2:0] act_bin;
    logic [2:0] act_oh;

    int checks = 0;
    int failures = 0;
    int model_st = 2;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seqctl_top #(.ONE_HOT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .sym_in(sym_in), .act_out(act_bin));

    seqctl_top #(.ONE_HOT(1'b1)) u_dut_oh (
        .clk(clk), .rst(rst), .sym_in(sym_in), .act_out(act_oh));

    function automatic int ref_next(int s, logic [2:0] v);
        if ($isunknown(v)) return 2;
        if (!v[2]) return 2;
        if (s == 0 || s == 1 || s == 3 || s == 4) return v[0] ? 1 : 0;
        if (s == 2) begin
            if (v[1:0] == 2'b00) return 2;
            return (v[1:0] == 2'b01) ? 5 : (v[1:0] == 2'b10) ? 4 : 3;
        end
        if (v[1:0] == 2'b00) return 2;
        return (v[1:0] == 2'b10) ? 4 : 3;
    endfunction

    function automatic logic [2:0] ref_act(int s, logic [2:0] v);
        logic [2:0] a;
        if ($isunknown(v)) return 3'b000;
        if (!v[2]) return (s <= 1) ? 3'b100 : 3'b000;
        a = 3'b000;
        a[0] = v[1];
        a[1] = v[0] && (s == 1 || s == 3 || s == 5);
        return a;
    endfunction

    task automatic check(string req, string what, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b (state S%0d)", req, what, got, exp, model_st);
        end
    endtask

    // Drive at falling edge, check mid-low-phase, advance the model at rising edge.
    task automatic step(logic r, logic [2:0] v, string req);
        logic [2:0] exp;
        @(negedge clk);
        rst = r;
        sym_in = v;
        #2;
        exp = ref_act(model_st, v);
        check(req, "binary act", act_bin, exp);
        check(req, "onehot act", act_oh, exp);
        check("R11", "encoding match", act_oh, act_bin);
        @(posedge clk);
        model_st = r ? 2 : ref_next(model_st, v);
    endtask

    task automatic go_to(int s);
        step(1'b1, 3'b000, "R1");
        case (s)
            0: begin step(1'b0, 3'b111, "R5"); step(1'b0, 3'b110, "R6"); end
            1: begin step(1'b0, 3'b111, "R5"); step(1'b0, 3'b111, "R6"); end
            3: step(1'b0, 3'b111, "R5");
            4: step(1'b0, 3'b110, "R5");
            5: step(1'b0, 3'b101, "R5");
            default: ;
        endcase
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        string tags [6];
        tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5";
        tags[3] = "R6"; tags[4] = "R7"; tags[5] = "R8";

        // R1: reset lands in S2; probe S2 behaviour right after reset.
        step(1'b1, 3'b111, "R1");
        step(1'b1, 3'b101, "R1");
        step(1'b0, 3'b111, "R1");

        // Full sweep: every state, every symbol (R2 for leading 0).
        for (int s = 0; s < 6; s++) begin
            for (int v = 0; v < 8; v++) begin
                go_to(s);
                step(1'b0, 3'(v), (v < 4) ? "R2" : tags[s]);
                step(1'b0, 3'b000, "R9");
            end
        end

        // R1: reset applied mid-run from a non-reset state.
        go_to(1);
        step(1'b1, 3'b111, "R1");
        step(1'b0, 3'b110, "R1");

        // R10: unknown symbols in several states.
        for (int s = 0; s < 6; s++) begin
            go_to(s);
            step(1'b0, 3'bx1x, "R10");
            step(1'b0, 3'b111, "R10");
            step(1'b0, 3'b1x0, "R10");
            step(1'b0, 3'b101, "R10");
        end

        // R9/R11: long pseudo-random walk, mostly leading-1 symbols.
        lfsr = 16'hACE1;
        step(1'b1, 3'b000, "R1");
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] v;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = lfsr[2:0];
            if (lfsr[7:5] != 3'b000) v[2] = 1'b1;
            step(1'b0, v, "R9");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule